// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Write Slave

This block is the device side of a three-wire serial EEPROM write port. An external master holds chip select high and clocks bits in on the serial clock. The bits are a start bit, a two-bit opcode, a ten-bit address field and the data word. When chip select falls after a complete write frame, a self-timed programming cycle starts. When that cycle ends, the word is stored in a register-array memory.

The whole block runs on a fast system clock and samples the serial pins as ordinary synchronous inputs. A rising edge on the serial clock is detected by comparing its value with the value registered one clock earlier. The programming time is a parameterised cycle count. While that count runs, the serial pins are ignored. The master can poll progress by raising chip select: the data-out pin then shows 0 while programming is in progress and 1 once it has finished. A new start bit takes the pin back to high impedance. A read port and a busy flag give the bench access to the stored words.

Top module: `mw_eeprom_wr`

## Requirements
- R1: A frame is read on rising edges of `sk_i` while `cs_i` is high. Zeros before the first 1 are skipped. That 1 is the start bit. Then come two opcode bits, one don't-care bit, address bits 8 down to 0, and data bits MSB first. Opcode 2'b01 is the write command.
- R2: When `cs_i` falls after a write frame with at least 16 data bits, a write is launched. The word appears at `rd_data_o` for that address once `busy_o` drops.
- R3: If more than 16 data bits are clocked in, the word stored is the last 16 bits received.
- R4: A frame with fewer than 16 data bits, or with an opcode other than 2'b01, launches nothing. `busy_o` stays 0 and memory is unchanged.
- R5: `busy_o` rises on the clock after the one that samples `cs_i` low. It stays high for exactly `PROG_CYCLES` clocks.
- R6: While `busy_o` is high, `sk_i` and `di_i` are ignored. A complete frame sent then, followed by `cs_i` falling, writes nothing and does not extend or restart the busy period.
- R7: After a launch and before the next start bit, `do_oe_o` is 1 whenever `cs_i` is high. `do_o` is then 0 while busy and 1 when ready, and it can be polled any number of times.
- R8: A start bit sampled while the pin is showing ready makes `do_oe_o` 0 on the next clock, and that bit begins a new frame.
- R9: `do_oe_o` is 0 whenever `cs_i` is low, and throughout any frame being shifted in.
- R10: After reset, `busy_o` and `do_oe_o` are 0 and every memory word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock; bits are taken on its rising edge |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Status value: 1 ready, 0 busy |
| do_oe_o | output | 1 | Output enable for do_o; 0 means high impedance |
| busy_o | output | 1 | Programming cycle in progress |
| rd_addr_i | input | ADDR_W | Memory read address (bench access) |
| rd_data_o | output | DATA_W | Word stored at rd_addr_i |

## Verification
The checker watches the status pin on every cycle. It confirms that the pin shows 0 while busy and 1 when ready, that it is off while chip select is low, and that a start bit taken while ready releases it. It also checks that each busy period begins just after chip select was low and lasts exactly the programmed count. What was stored, and where, can only be shown by the bench's scenarios. These cover the last-16-bit rule for overlong data, aborted and wrong-opcode frames, and frames sent during programming that must leave memory unchanged.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int OP_W = 2;
  localparam logic [OP_W-1:0] OP_WRITE = 2'b01;
  typedef enum logic [1:0] {RX_IDLE, RX_HDR, RX_DATA} rx_state_e;
endpackage

// File: rtl/mw_frame_rx.sv
module mw_frame_rx
  import mw_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              bit_stb_i,
  input  logic              bit_i,
  output logic              start_o,
  output logic              frame_ok_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int HDR_BITS = OP_W + 1 + ADDR_W;
  localparam int KEEP_W   = OP_W + ADDR_W;
  localparam int HCNT_W   = $clog2(HDR_BITS + 1);
  localparam int DCNT_W   = $clog2(DATA_W + 1);
  localparam logic [HCNT_W-1:0] HCNT_SKIP = HCNT_W'(OP_W);
  localparam logic [HCNT_W-1:0] HCNT_LAST = HCNT_W'(HDR_BITS - 1);
  localparam logic [DCNT_W-1:0] DCNT_FULL = DCNT_W'(DATA_W);

  rx_state_e         state_q;
  logic [HCNT_W-1:0] hcnt_q;
  logic [DCNT_W-1:0] dcnt_q;
  logic [KEEP_W-1:0] hdr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      hcnt_q  <= '0;
      dcnt_q  <= '0;
      hdr_q   <= '0;
      data_q  <= '0;
    end else if (!en_i) begin
      state_q <= RX_IDLE;
      hcnt_q  <= '0;
      dcnt_q  <= '0;
    end else if (bit_stb_i) begin
      case (state_q)
        RX_IDLE: if (bit_i) begin
          state_q <= RX_HDR;
          hcnt_q  <= '0;
        end
        RX_HDR: begin
          // don't-care bit after the opcode is dropped
          if (hcnt_q != HCNT_SKIP) hdr_q <= {hdr_q[KEEP_W-2:0], bit_i};
          if (hcnt_q == HCNT_LAST) begin
            state_q <= RX_DATA;
            dcnt_q  <= '0;
          end
          hcnt_q <= hcnt_q + 1'b1;
        end
        RX_DATA: begin
          data_q <= {data_q[DATA_W-2:0], bit_i};
          if (dcnt_q != DCNT_FULL) dcnt_q <= dcnt_q + 1'b1;
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assign start_o    = en_i & bit_stb_i & bit_i & (state_q == RX_IDLE);
  assign frame_ok_o = (state_q == RX_DATA) && (dcnt_q == DCNT_FULL) &&
                      (hdr_q[KEEP_W-1 -: OP_W] == OP_WRITE);
  assign addr_o     = hdr_q[ADDR_W-1:0];
  assign data_o     = data_q;
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
  parameter int PROG_CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PROG_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= LOAD;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);
endmodule

// File: rtl/mw_word_mem.sv
module mw_word_mem #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/mw_eeprom_wr.sv
module mw_eeprom_wr #(
  parameter int ADDR_W      = 9,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              sk_i,
  input  logic              di_i,
  output logic              do_o,
  output logic              do_oe_o,
  output logic              busy_o,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic sk_q, cs_q, sk_rise, cs_fall;
  logic busy, done, launch, rx_en, rx_start, frame_ok, armed_q;
  logic [ADDR_W-1:0] rx_addr, pend_addr_q;
  logic [DATA_W-1:0] rx_data, pend_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sk_q <= 1'b0;
      cs_q <= 1'b0;
    end else begin
      sk_q <= sk_i;
      cs_q <= cs_i;
    end
  end

  assign sk_rise = sk_i & ~sk_q;
  assign cs_fall = cs_q & ~cs_i;
  assign rx_en   = cs_i & ~busy;
  assign launch  = cs_fall & frame_ok & ~busy;

  mw_frame_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (rx_en),
    .bit_stb_i (sk_rise),
    .bit_i     (di_i),
    .start_o   (rx_start),
    .frame_ok_o(frame_ok),
    .addr_o    (rx_addr),
    .data_o    (rx_data)
  );

  mw_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(launch),
    .busy_o (busy),
    .done_o (done)
  );

  // status stays armed from launch until the next start bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_addr_q <= '0;
      pend_data_q <= '0;
      armed_q     <= 1'b0;
    end else begin
      if (launch) begin
        pend_addr_q <= rx_addr;
        pend_data_q <= rx_data;
      end
      if (launch)        armed_q <= 1'b1;
      else if (rx_start) armed_q <= 1'b0;
    end
  end

  mw_word_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (done),
    .waddr_i(pend_addr_q),
    .wdata_i(pend_data_q),
    .raddr_i(rd_addr_i),
    .rdata_o(rd_data_o)
  );

  assign busy_o  = busy;
  assign do_o    = ~busy;
  assign do_oe_o = cs_i & armed_q;
endmodule

// File: rtl/mw_eeprom_wr_chk.sv
module mw_eeprom_wr_chk #(
  parameter int PROG_CYCLES = 1000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_i,
  input logic sk_i,
  input logic di_i,
  input logic do_o,
  input logic do_oe_o,
  input logic busy_o
);
  logic [31:0] run_q;
  logic        sk_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= '0;
      sk_prev_q <= 1'b0;
    end else begin
      run_q     <= busy_o ? run_q + 1 : '0;
      sk_prev_q <= sk_i;
    end
  end

  p_busy_after_cs_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !$past(cs_i));
  p_busy_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_q == PROG_CYCLES));
  p_busy_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (run_q < PROG_CYCLES));
  p_do_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_oe_o && busy_o) |-> !do_o);
  p_do_ready_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_oe_o && !busy_o) |-> do_o);
  p_hiz_cs_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |-> !do_oe_o);
  p_start_hiz_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_oe_o && !busy_o && cs_i && sk_i && !sk_prev_q && di_i) |=> !do_oe_o);
endmodule

bind mw_eeprom_wr mw_eeprom_wr_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cs_i   (cs_i),
  .sk_i   (sk_i),
  .di_i   (di_i),
  .do_o   (do_o),
  .do_oe_o(do_oe_o),
  .busy_o (busy_o)
);

// File: tb/mw_eeprom_wr_test.sv
module mw_eeprom_wr_test;
  localparam int AW   = 9;
  localparam int DW   = 16;
  localparam int PROG = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_v, do_oe, busy;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] exp_mem [1 << AW];

  always #5 clk = ~clk;

  mw_eeprom_wr #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PROG)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
    .do_o(do_v), .do_oe_o(do_oe), .busy_o(busy),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] last_word(input logic [31:0] bits);
    return bits[DW-1:0];
  endfunction

  task automatic sk_bit(input logic b);
    @(negedge clk) di = b;
    @(negedge clk) sk = 1'b1;
    @(negedge clk);
    @(negedge clk) sk = 1'b0;
    @(negedge clk);
  endtask

  // leaves cs high; data bits sent from bit nbits-1 down to 0
  task automatic send_frame(input int lead, input logic [1:0] op, input logic [AW-1:0] a,
                            input logic [31:0] d, input int nbits, input bit hiz_chk);
    @(negedge clk) cs = 1'b1;
    for (int i = 0; i < lead; i++) sk_bit(1'b0);
    sk_bit(1'b1);
    if (hiz_chk) chk("R9 frame hiz", do_oe, 0);
    sk_bit(op[1]);
    sk_bit(op[0]);
    sk_bit($urandom % 2);
    for (int i = AW - 1; i >= 0; i--) sk_bit(a[i]);
    for (int i = nbits - 1; i >= 0; i--) sk_bit(d[i]);
    if (hiz_chk) chk("R9 shift hiz", do_oe, 0);
  endtask

  task automatic drop_cs;
    @(negedge clk) cs = 1'b0;
    di = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    for (int i = 0; i < PROG + 50; i++) begin
      @(negedge clk);
      if (busy) n++;
      else if (n > 0) break;
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk) rd_addr = a;
    #1 d = rd_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    logic [DW-1:0] r;
    logic [AW-1:0] a;
    logic [31:0] d;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < (1 << AW); i++) exp_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk) cs = 1'b1;
    @(negedge clk);
    // R10: reset state, pin off even with cs high
    chk("R10 busy", busy, 0);
    chk("R10 oe", do_oe, 0);
    rd(9'd0, r);   chk("R10 mem0", r, 0);
    rd(9'd511, r); chk("R10 mem511", r, 0);

    // R1/R2: leading zeros, plain write
    send_frame(3, 2'b01, 9'd5, 32'h0000_a5c3, 16, 1);
    drop_cs();
    @(negedge clk);
    chk("R5 busy rises", busy, 1);
    chk("R9 cs low oe", do_oe, 0);
    repeat (4) @(negedge clk);
    cs = 1'b1;
    @(negedge clk);
    chk("R7 oe busy", do_oe, 1);
    chk("R7 do busy", do_v, 0);
    @(negedge clk);
    chk("R7 repoll busy", do_v, 0);
    while (busy) @(negedge clk);
    @(negedge clk);
    chk("R7 oe ready", do_oe, 1);
    chk("R7 do ready", do_v, 1);
    rd(9'd5, r); chk("R2 word", r, 16'ha5c3);
    exp_mem[5] = 16'ha5c3;

    // R8 + R3: start bit while ready, overlong data
    send_frame(0, 2'b01, 9'h1a7, 32'h000f_1234, 20, 1);
    drop_cs();
    wait_done(n);
    chk("R5 busy length", n, PROG);
    exp_mem[9'h1a7] = last_word(32'h000f_1234);
    rd(9'h1a7, r); chk("R3 last16", r, exp_mem[9'h1a7]);

    // R4: abort and wrong opcode
    send_frame(0, 2'b01, 9'd77, 32'h0000_1fff, 13, 1);
    drop_cs();
    repeat (5) @(negedge clk);
    chk("R4 abort busy", busy, 0);
    rd(9'd77, r); chk("R4 abort mem", r, 0);
    send_frame(0, 2'b11, 9'd78, 32'h0000_beef, 16, 1);
    drop_cs();
    repeat (5) @(negedge clk);
    chk("R4 opcode busy", busy, 0);
    rd(9'd78, r); chk("R4 opcode mem", r, 0);

    // R6: frame during programming ignored
    send_frame(0, 2'b01, 9'd200, 32'h0000_4321, 16, 1);
    drop_cs();
    @(negedge clk);
    send_frame(0, 2'b01, 9'd201, 32'h0000_9999, 16, 0);
    chk("R6 still busy", busy, 1);
    drop_cs();
    wait_done(n);
    repeat (5) @(negedge clk);
    chk("R6 no restart", busy, 0);
    exp_mem[200] = 16'h4321;
    rd(9'd201, r); chk("R6 ignored mem", r, 0);
    rd(9'd200, r); chk("R6 first write", r, 16'h4321);

    // random mix
    for (int k = 0; k < 24; k++) begin
      bit abort;
      int nb;
      a = AW'($urandom);
      d = $urandom;
      abort = ($urandom % 5) == 0;
      nb = abort ? 1 + ($urandom % 15) : 16 + ($urandom % 7);
      send_frame($urandom % 3, 2'b01, a, d, nb, 1);
      drop_cs();
      if (abort) begin
        repeat (4) @(negedge clk);
        chk("R4 rand abort", busy, 0);
      end else begin
        wait_done(n);
        chk("R5 rand length", n, PROG);
        exp_mem[a] = last_word(d & ((nb == 32) ? 32'hffff_ffff : ((32'd1 << nb) - 1)));
      end
      rd(a, r);
      chk(abort ? "R4 rand mem" : "R2 rand mem", r, exp_mem[a]);
    end
    rd(9'd5, r); chk("R2 earlier word kept", r, exp_mem[5]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule